// File: doc/BRIEF.md
# Serial Conversion Result Receiver

This block sits on the host side of a successive-approximation converter and rebuilds each conversion result from the converter's serial output. The converter supplies three signals that are asynchronous to the host: a bit clock, a busy flag and an NRZ data line. The block brings all three into the system clock domain with an equal number of synchronizer stages. It shifts a data bit in on every falling edge of the bit clock. When the busy flag falls, it takes the finished word from the shift register.

The converter sends its result in complemented form. The first bit of every conversion is meaningless, and the number of bits sent depends on how far the conversion was allowed to run. The block keeps only the most recent 8, 10 or 12 bits, as chosen by a resolution input, which discards the leading junk bit. It then undoes the complement, producing straight binary, offset binary or sign-extended two's complement as chosen by a format input. The result appears on a registered word output together with a strobe that lasts one system clock. The word then holds until the next busy-flag fall.

Top module: `sercap_rx`

## Requirements
- R1: While reset is high and after it is released, with no conversion finished yet, `word_o` is 0 and `word_valid_o` is 0.
- R2: Data bits are taken from `conv_sdat_i` only on falling edges of `conv_clk_i`, seen through the synchronizers, and arrive most significant bit first.
- R3: For a 12-bit conversion there are 13 falling bit-clock edges, and the bit sampled on the first one never reaches `word_o`.
- R4: Each falling edge of `conv_stat_i` raises `word_valid_o` for exactly one system clock, with the new word on `word_o` in that same cycle.
- R5: With `fmt_sel_i` = 0 (straight binary), `word_o` is the bitwise inverse of the last N received bits, right-justified and zero-extended.
- R6: With `fmt_sel_i` = 1 (offset binary) or 3, `word_o` is the bitwise inverse of the last N received bits, right-justified and zero-extended.
- R7: With `fmt_sel_i` = 2 (two's complement), `word_o` is the inverse of the last N received bits with bit N-1 flipped back, sign-extended from bit N-1 to the full width.
- R8: `res_sel_i` sets N: 0 gives 12, 1 gives 10, 2 gives 8, and 3 gives 12.
- R9: After a strobe, `word_o` keeps its value while the next conversion is in progress, and no strobe occurs until the busy flag falls again.
- R10: If a falling bit-clock edge and the busy-flag fall are seen in the same system cycle, the bit from that edge is shifted in before the word is captured.
- R11: `word_o` changes only in a cycle where `word_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_clk_i | input | 1 | Converter bit clock, asynchronous |
| conv_stat_i | input | 1 | Converter busy flag, asynchronous, high during a conversion |
| conv_sdat_i | input | 1 | Converter serial data, complemented NRZ |
| fmt_sel_i | input | 2 | Output format: 0 straight, 1 offset, 2 two's complement, 3 offset |
| res_sel_i | input | 2 | Bits kept: 0 twelve, 1 ten, 2 eight, 3 twelve |
| word_o | output | 12 | Decoded conversion result |
| word_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A shift register that is off by one position shows up on the first strobe as a word shifted by one bit, with the junk leading bit appearing at the top. A wrong decode of the format or resolution select shows up in the same way, on the first strobe that uses that setting. A faulty edge detector on the busy flag shows up as a strobe that is missing, duplicated or longer than one cycle, visible within one system clock of the flag's fall. A fault in the hold path shows up as `word_o` changing in the middle of the next conversion, long before that conversion's strobe.

// File: rtl/sercap_pkg.sv
package sercap_pkg;
  typedef enum logic [1:0] {
    FMT_STRAIGHT = 2'd0,
    FMT_OFFSET   = 2'd1,
    FMT_TWOS     = 2'd2,
    FMT_ALT      = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    RES_FULL  = 2'd0,
    RES_MID   = 2'd1,
    RES_LOW   = 2'd2,
    RES_SPARE = 2'd3
  } res_e;
endpackage

// File: rtl/sercap_sync.sv
module sercap_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sercap_shift.sv
module sercap_shift #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_i,
  output logic [WIDTH-1:0] sh_q,
  output logic [WIDTH-1:0] sh_next
);
  always_comb begin
    sh_next = sh_q;
    if (shift_en) sh_next = {sh_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= sh_next;
  end

  // R2: the register moves only on a detected bit-clock fall
  a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/sercap_decode.sv
module sercap_decode
  import sercap_pkg::*;
#(
  parameter int MAX_BITS = 12
) (
  input  logic [MAX_BITS-1:0] raw_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          res_i,
  output logic [MAX_BITS-1:0] word_o
);
  localparam int N_MID = MAX_BITS - 2;
  localparam int N_LOW = MAX_BITS - 4;

  int   nb;
  logic sign;

  always_comb begin
    case (res_e'(res_i))
      RES_MID: nb = N_MID;
      RES_LOW: nb = N_LOW;
      default: nb = MAX_BITS;
    endcase
  end

  // true MSB is ~raw; flipping it for two's complement gives raw again
  assign sign = raw_i[nb-1];

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < nb) begin
        if (fmt_e'(fmt_i) == FMT_TWOS && i == nb - 1) word_o[i] = raw_i[i];
        else                                           word_o[i] = ~raw_i[i];
      end else begin
        word_o[i] = (fmt_e'(fmt_i) == FMT_TWOS) ? sign : 1'b0;
      end
    end
  end
endmodule

// File: rtl/sercap_rx.sv
module sercap_rx
  import sercap_pkg::*;
#(
  parameter int MAX_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_clk_i,
  input  logic                conv_stat_i,
  input  logic                conv_sdat_i,
  input  logic [1:0]          fmt_sel_i,
  input  logic [1:0]          res_sel_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic                word_valid_o
);
  localparam int SIG_CLK = 0;
  localparam int SIG_STA = 1;
  localparam int SIG_DAT = 2;

  logic [2:0]          sync_s;
  logic                bclk_d, stat_d;
  logic                bclk_fall, stat_fall;
  logic [MAX_BITS-1:0] sh_q, sh_next, dec_word;

  sercap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({conv_sdat_i, conv_stat_i, conv_clk_i}),
    .sync_o  (sync_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      stat_d <= 1'b0;
    end else begin
      bclk_d <= sync_s[SIG_CLK];
      stat_d <= sync_s[SIG_STA];
    end
  end

  assign bclk_fall = bclk_d & ~sync_s[SIG_CLK];
  assign stat_fall = stat_d & ~sync_s[SIG_STA];

  sercap_shift #(.WIDTH(MAX_BITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bclk_fall),
    .bit_i    (sync_s[SIG_DAT]),
    .sh_q     (sh_q),
    .sh_next  (sh_next)
  );

  // decode the next shift value so a coincident last bit is included
  sercap_decode #(.MAX_BITS(MAX_BITS)) u_dec (
    .raw_i  (sh_next),
    .fmt_i  (fmt_sel_i),
    .res_i  (res_sel_i),
    .word_o (dec_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= stat_fall;
      if (stat_fall) word_o <= dec_word;
    end
  end

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  a_r4_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
    stat_fall |=> word_valid_o);

  a_r11_word_moves_with_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_o) |-> word_valid_o);

  a_r9_no_strobe_while_busy: assert property (@(posedge clk) disable iff (rst)
    (stat_d && sync_s[SIG_STA]) |=> !word_valid_o);
endmodule

// File: tb/sim_sercap_rx.sv
module sim_sercap_rx;
  logic        clk = 1'b0;
  logic        rst;
  logic        conv_clk_i, conv_stat_i, conv_sdat_i;
  logic [1:0]  fmt_sel_i, res_sel_i;
  logic [11:0] word_o;
  logic        word_valid_o;

  always #10 clk = ~clk;

  sercap_rx u0 (
    .clk(clk), .rst(rst),
    .conv_clk_i(conv_clk_i), .conv_stat_i(conv_stat_i), .conv_sdat_i(conv_sdat_i),
    .fmt_sel_i(fmt_sel_i), .res_sel_i(res_sel_i),
    .word_o(word_o), .word_valid_o(word_valid_o)
  );

  localparam int HP = 4;

  logic [11:0] exp_q [$];
  string       tag_q [$];
  int          checks = 0;
  int          fails  = 0;
  logic [11:0] last_exp = '0;
  logic        vprev = 1'b0;
  logic [11:0] m_exp;
  string       m_tag;

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  function automatic logic [11:0] exp_of(input logic [11:0] tv, input logic [1:0] fmt, input logic [1:0] res);
    int n;
    logic [11:0] mask, v;
    n = (res == 2'd1) ? 10 : (res == 2'd2) ? 8 : 12;
    mask = 12'hFFF >> (12 - n);
    v = tv & mask;
    if (fmt == 2'd2) begin
      v[n-1] = ~v[n-1];
      if (v[n-1]) v = v | ~mask;
    end
    return v;
  endfunction

  // driver: pushes the expected word, then plays one conversion
  task automatic send(input logic [11:0] tv, input logic [1:0] fmt, input logic [1:0] res,
                      input bit coincide, input bit hold_chk, input string tag);
    int n;
    n = (res == 2'd1) ? 10 : (res == 2'd2) ? 8 : 12;
    exp_q.push_back(exp_of(tv, fmt, res));
    tag_q.push_back(tag);
    fmt_sel_i   = fmt;
    res_sel_i   = res;
    conv_stat_i = 1'b1;
    cyc(3);
    for (int k = 0; k <= n; k++) begin
      conv_clk_i  = 1'b1;
      // leading bit is junk: send the opposite of the first real bit
      conv_sdat_i = (k == 0) ? tv[n-1] : ~tv[n-k];
      cyc(HP);
      conv_clk_i = 1'b0;
      if (k == n && coincide) conv_stat_i = 1'b0;
      if (hold_chk && k == 5) begin
        // R9: previous word held mid-conversion
        check(word_o == last_exp, "R9 word held during next conversion", word_o, last_exp);
      end
      cyc(HP);
    end
    if (!coincide) begin
      cyc(2);
      conv_stat_i = 1'b0;
    end
    cyc(8);
    last_exp = exp_of(tv, fmt, res);
  endtask

  // monitor: pops and compares on every strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid_o) begin
        if (vprev) check(1'b0, "R4 strobe longer than one cycle", 12'd1, 12'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 strobe with no conversion finished", word_o, 12'd0);
        end else begin
          m_exp = exp_q.pop_front();
          m_tag = tag_q.pop_front();
          check(word_o == m_exp, m_tag, word_o, m_exp);
        end
      end
      vprev = word_valid_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    conv_clk_i = 1'b0; conv_stat_i = 1'b0; conv_sdat_i = 1'b0;
    fmt_sel_i = 2'd0; res_sel_i = 2'd0;
    cyc(4);
    check(word_o == 12'd0, "R1 word in reset", word_o, 12'd0);
    check({11'd0, word_valid_o} == 12'd0, "R1 strobe in reset", {11'd0, word_valid_o}, 12'd0);
    rst = 1'b0;
    cyc(3);
    check(word_o == 12'd0, "R1 word after reset", word_o, 12'd0);
    check({11'd0, word_valid_o} == 12'd0, "R1 strobe after reset", {11'd0, word_valid_o}, 12'd0);

    send(12'h676, 2'd0, 2'd0, 1'b0, 1'b0, "R2 R3 R5 straight 12-bit 676");
    send(12'h000, 2'd0, 2'd0, 1'b0, 1'b1, "R5 straight zero");
    send(12'hFFF, 2'd0, 2'd0, 1'b0, 1'b1, "R5 straight full scale");
    send(12'hA5C, 2'd1, 2'd0, 1'b0, 1'b0, "R6 offset 12-bit");
    send(12'h3C1, 2'd3, 2'd0, 1'b0, 1'b0, "R6 format 3 acts as offset");
    send(12'h800, 2'd2, 2'd0, 1'b0, 1'b0, "R7 twos mid-scale to zero");
    send(12'h7FF, 2'd2, 2'd0, 1'b0, 1'b1, "R7 twos minus one");
    send(12'h3FF, 2'd2, 2'd1, 1'b0, 1'b0, "R7 R8 twos 10-bit positive");
    send(12'h000, 2'd2, 2'd1, 1'b0, 1'b0, "R7 R8 twos 10-bit sign extend");
    send(12'h2B7, 2'd0, 2'd1, 1'b0, 1'b0, "R8 straight 10-bit");
    send(12'h0C3, 2'd0, 2'd2, 1'b0, 1'b0, "R8 straight 8-bit");
    send(12'h05A, 2'd2, 2'd2, 1'b0, 1'b1, "R8 R7 twos 8-bit");
    send(12'h9E4, 2'd1, 2'd3, 1'b0, 1'b0, "R8 select 3 gives 12 bits");
    send(12'h5A5, 2'd0, 2'd0, 1'b1, 1'b0, "R10 coincident last edge");
    send(12'h0F1, 2'd1, 2'd1, 1'b1, 1'b0, "R10 coincident 10-bit");

    cyc(10);
    check(exp_q.size() == 0, "R4 every conversion strobed", 12'(exp_q.size()), 12'd0);
    check(word_o == last_exp, "R11 word stable after last strobe", word_o, last_exp);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule